// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit with Status Flags

This block is a purely combinational integer arithmetic-logic unit for a processor datapath. It takes two operands, a six-bit incoming status vector, a four-bit operation code and a two-bit width select. It returns a result, a six-bit outgoing status vector and a result write-enable. The eight classic two-operand operations are covered, together with increment, decrement and the two decimal-adjust steps that fix up the low byte after a packed-BCD add or subtract.

Each operation class has its own flag rule. Arithmetic operations produce all six flags. Logical operations clear overflow and carry. Increment and decrement keep the incoming carry. The decimal adjusts consume the incoming auxiliary and carry flags. Every flag that the architecture leaves undefined is driven to 0, so the outputs are always deterministic.

The surrounding pipeline fetches the operands, writes `result_o` back when `wr_en_o` is high, and stores `flags_o` as the new status.

Top module: `alu_core`

## Requirements
- R1: The operation codes are 0 ADD, 1 OR, 2 ADC, 3 SBB, 4 AND, 5 SUB, 6 XOR, 7 CMP, 8 INC, 9 DEC, 10 decimal adjust after add, 11 decimal adjust after subtract. ADD and SUB return a+b and a−b truncated to the selected width. For every code from 0 to 9, result bits above the width are 0.
- R2: ADC adds the incoming carry flag. SBB subtracts the incoming carry flag as a borrow.
- R3: For codes 0, 2, 3, 5, 7, 8 and 9, the flags are set as follows. A is the carry out of bit 3 (or the borrow into bit 4). O is signed overflow at the width's sign bit. C is the carry out of the width (or the borrow into it); codes 8 and 9 are the exception, see R7.
- R4: The flags vector is {O,S,Z,A,P,C}, with bit 5 = O and bit 0 = C. S is the top bit of the result at the width. Z is set when the result at the width is zero. P is set when the low 8 result bits hold an even number of ones.
- R5: OR, AND and XOR return the bitwise result and clear O, C and A.
- R6: CMP sets the flags exactly as SUB would and holds `wr_en_o` low. Codes 0 to 6 and 8 to 11 hold `wr_en_o` high.
- R7: INC and DEC add or subtract 1, ignore `b_i`, and pass the incoming C through unchanged.
- R8: Code 10 works on the low byte of `a_i`. It adds 6 when the low nibble exceeds 9 or incoming A is set, and it adds 0x60 when the original byte exceeds 0x99 or incoming C is set. A and C report whether each of these steps was taken.
- R9: Code 11 applies the same two conditions as R8 but subtracts 6 and 0x60, with A and C set the same way.
- R10: For codes 10 and 11 the width select is ignored. Result bits above bit 7 repeat `a_i`, O is 0, and S, Z and P come from the adjusted low byte.
- R11: Codes 12 to 15 give a zero result, hold `wr_en_o` low and pass `flags_i` to `flags_o` unchanged.
- R12: Width codes are 0 = 8 bits, 1 = 16 bits, and both 2 and 3 = 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| width_i | input | 2 | Operand width select |
| a_i | input | DATA_W | First operand |
| b_i | input | DATA_W | Second operand |
| flags_i | input | 6 | Incoming status {O,S,Z,A,P,C} |
| result_o | output | DATA_W | Operation result |
| flags_o | output | 6 | Outgoing status {O,S,Z,A,P,C} |
| wr_en_o | output | 1 | Result write-enable |

## Verification
The embedded assertions take for granted that the inputs are settled two-state values and that `DATA_W` is at least 32, so that every width code fits inside the operand. The bench drives only known values: every opcode from 0 to 15 and every width code, including the reserved ones, which are legal inputs with defined behaviour. It draws operands both at random and from edge values near each width's sign and carry boundaries, and it pairs them with all combinations of incoming A and C. This keeps the stimulus inside those assumptions while still exercising every flag rule.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int unsigned FLAG_W = 6;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_OR   = 4'd1,
        OP_ADC  = 4'd2,
        OP_SBB  = 4'd3,
        OP_AND  = 4'd4,
        OP_SUB  = 4'd5,
        OP_XOR  = 4'd6,
        OP_CMP  = 4'd7,
        OP_INC  = 4'd8,
        OP_DEC  = 4'd9,
        OP_DADD = 4'd10,
        OP_DSUB = 4'd11
    } alu_op_e;

    typedef enum logic [1:0] {
        W_8   = 2'd0,
        W_16  = 2'd1,
        W_32  = 2'd2,
        W_32X = 2'd3
    } alu_width_e;

    // packed MSB first: bit 5 = o ... bit 0 = c
    typedef struct packed {
        logic o;
        logic s;
        logic z;
        logic a;
        logic p;
        logic c;
    } alu_flags_t;

    function automatic int unsigned width_bits(alu_width_e w);
        case (w)
            W_8:     return 8;
            W_16:    return 16;
            default: return 32;
        endcase
    endfunction

    function automatic logic even_ones8(logic [7:0] v);
        return ~(^v);
    endfunction

    function automatic logic is_logic_op(alu_op_e op);
        return (op == OP_OR) || (op == OP_AND) || (op == OP_XOR);
    endfunction

    function automatic logic is_arith_op(alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) ||
               (op == OP_SBB) || (op == OP_CMP);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    input  logic              sub_i,
    input  logic [DATA_W-1:0] mask_i,
    input  alu_width_e        width_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              carry_o,
    output logic              aux_o,
    output logic              ovf_o
);
    localparam int unsigned IDX_W = $clog2(DATA_W + 1);

    logic [DATA_W:0]    am, bm, cm, ext;
    logic [IDX_W-1:0]   top_idx, sgn_idx;
    logic               sa, sb, sr;

    always_comb begin
        top_idx = IDX_W'(width_bits(width_i));
        sgn_idx = IDX_W'(width_bits(width_i) - 1);
        am      = {1'b0, a_i & mask_i};
        bm      = {1'b0, b_i & mask_i};
        cm      = {{DATA_W{1'b0}}, cin_i};
        ext     = sub_i ? (am - bm - cm) : (am + bm + cm);
        sum_o   = ext[DATA_W-1:0] & mask_i;
        carry_o = ext[top_idx];
        aux_o   = am[4] ^ bm[4] ^ ext[4];
        sa      = am[sgn_idx];
        sb      = bm[sgn_idx];
        sr      = ext[sgn_idx];
        ovf_o   = sub_i ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
    end

    always_comb begin
        if (sub_i && !cin_i) begin
            AST_BORROW_MATCHES_ORDER: assert (carry_o == (am < bm))   // R3
                else $error("borrow does not match operand order");
        end
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] mask_i,
    output logic [DATA_W-1:0] res_o
);
    logic [DATA_W-1:0] raw;

    always_comb begin
        case (op_i)
            OP_OR:   raw = a_i | b_i;
            OP_AND:  raw = a_i & b_i;
            OP_XOR:  raw = a_i ^ b_i;
            default: raw = '0;
        endcase
        res_o = raw & mask_i;
    end

endmodule

// File: rtl/alu_decadj.sv
module alu_decadj (
    input  logic [7:0] byte_i,
    input  logic       aux_i,
    input  logic       carry_i,
    input  logic       sub_i,
    output logic [7:0] byte_o,
    output logic       aux_o,
    output logic       carry_o
);
    logic       fix_lo, fix_hi;
    logic [7:0] lo_amt, hi_amt, mid;

    always_comb begin
        fix_lo  = (byte_i[3:0] > 4'd9) || aux_i;
        fix_hi  = (byte_i > 8'h99) || carry_i;
        lo_amt  = fix_lo ? 8'h06 : 8'h00;
        hi_amt  = fix_hi ? 8'h60 : 8'h00;
        mid     = sub_i ? (byte_i - lo_amt) : (byte_i + lo_amt);
        byte_o  = sub_i ? (mid - hi_amt) : (mid + hi_amt);
        aux_o   = fix_lo;
        carry_o = fix_hi;
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [3:0]        op_i,
    input  logic [1:0]        width_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [5:0]        flags_i,
    output logic [DATA_W-1:0] result_o,
    output logic [5:0]        flags_o,
    output logic              wr_en_o
);
    localparam int unsigned IDX_W = $clog2(DATA_W + 1);

    alu_op_e           op;
    alu_width_e        wsel;
    alu_flags_t        fin, fout;
    logic [DATA_W-1:0] wmask;
    logic [IDX_W-1:0]  sgn_idx;

    logic [DATA_W-1:0] as_b, as_sum, lg_res;
    logic              as_cin, as_sub, as_c, as_a, as_o;
    logic [7:0]        dj_byte;
    logic              dj_a, dj_c;
    logic              cls_arith, cls_logic, cls_step, cls_dec, cls_rsv;

    always_comb begin
        op        = alu_op_e'(op_i);
        wsel      = alu_width_e'(width_i);
        fin       = alu_flags_t'(flags_i);
        wmask     = {DATA_W{1'b1}} >> (DATA_W - width_bits(wsel));
        sgn_idx   = IDX_W'(width_bits(wsel) - 1);
        cls_arith = is_arith_op(op);
        cls_logic = is_logic_op(op);
        cls_step  = (op == OP_INC) || (op == OP_DEC);
        cls_dec   = (op == OP_DADD) || (op == OP_DSUB);
        cls_rsv   = (op_i > 4'd11);
    end

    // operand steering into the shared adder
    always_comb begin
        as_b   = b_i;
        as_cin = 1'b0;
        as_sub = 1'b0;
        case (op)
            OP_ADC:  as_cin = fin.c;
            OP_SBB:  begin as_sub = 1'b1; as_cin = fin.c; end
            OP_SUB,
            OP_CMP:  as_sub = 1'b1;
            OP_INC:  as_b = {{(DATA_W-1){1'b0}}, 1'b1};
            OP_DEC:  begin as_b = {{(DATA_W-1){1'b0}}, 1'b1}; as_sub = 1'b1; end
            default: ;
        endcase
    end

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a_i     (a_i),
        .b_i     (as_b),
        .cin_i   (as_cin),
        .sub_i   (as_sub),
        .mask_i  (wmask),
        .width_i (wsel),
        .sum_o   (as_sum),
        .carry_o (as_c),
        .aux_o   (as_a),
        .ovf_o   (as_o)
    );

    alu_logic #(.DATA_W(DATA_W)) u_logic (
        .a_i    (a_i),
        .b_i    (b_i),
        .op_i   (op),
        .mask_i (wmask),
        .res_o  (lg_res)
    );

    alu_decadj u_decadj (
        .byte_i  (a_i[7:0]),
        .aux_i   (fin.a),
        .carry_i (fin.c),
        .sub_i   (op == OP_DSUB),
        .byte_o  (dj_byte),
        .aux_o   (dj_a),
        .carry_o (dj_c)
    );

    always_comb begin
        result_o = '0;
        fout     = '0;
        wr_en_o  = 1'b1;
        if (cls_arith || cls_step) begin
            result_o = as_sum;
            fout.o   = as_o;
            fout.a   = as_a;
            fout.c   = cls_step ? fin.c : as_c;
            fout.s   = as_sum[sgn_idx];
            fout.z   = (as_sum == '0);
            fout.p   = even_ones8(as_sum[7:0]);
            wr_en_o  = (op != OP_CMP);
        end else if (cls_logic) begin
            result_o = lg_res;
            fout.s   = lg_res[sgn_idx];
            fout.z   = (lg_res == '0);
            fout.p   = even_ones8(lg_res[7:0]);
        end else if (cls_dec) begin
            result_o = {a_i[DATA_W-1:8], dj_byte};
            fout.a   = dj_a;
            fout.c   = dj_c;
            fout.s   = dj_byte[7];
            fout.z   = (dj_byte == 8'h00);
            fout.p   = even_ones8(dj_byte);
        end else begin
            fout     = fin;
            wr_en_o  = 1'b0;
        end
        flags_o = fout;
    end

    always_comb begin
        if (cls_logic) begin
            AST_LOGIC_CLEARS_OAC: assert (!flags_o[5] && !flags_o[2] && !flags_o[0])   // R5
                else $error("logical op left O, A or C set");
        end
        if (op == OP_CMP) begin
            AST_CMP_NO_WRITE: assert (!wr_en_o)   // R6
                else $error("compare asserted write-enable");
        end
        if (cls_step) begin
            AST_STEP_KEEPS_C: assert (flags_o[0] == flags_i[0])   // R7
                else $error("inc/dec changed carry");
        end
        if (cls_arith || cls_step || cls_logic) begin
            AST_UPPER_BITS_ZERO: assert ((result_o & ~wmask) == '0)   // R1
                else $error("result bits above width not zero");
        end
        if (cls_dec) begin
            AST_DEC_UPPER_AND_O: assert (!flags_o[5] && (result_o[DATA_W-1:8] == a_i[DATA_W-1:8]))   // R10
                else $error("decimal adjust touched O or upper bits");
        end
        if (cls_rsv) begin
            AST_RESERVED_HOLD: assert (!wr_en_o && (flags_o == flags_i) && (result_o == '0))   // R11
                else $error("reserved op not inert");
        end
    end

endmodule

// File: tb/tb_alu_core.sv
module tb_alu_core;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    op;
    logic [1:0]    wd;
    logic [DW-1:0] a, b;
    logic [5:0]    fi;
    logic [DW-1:0] res;
    logic [5:0]    fo;
    logic          we;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;   // 125 MHz

    alu_core #(.DATA_W(DW)) dut (
        .op_i(op), .width_i(wd), .a_i(a), .b_i(b), .flags_i(fi),
        .result_o(res), .flags_o(fo), .wr_en_o(we)
    );

    function automatic longint sval(longint x, int bits);
        return (x >= (longint'(1) << (bits - 1))) ? x - (longint'(1) << bits) : x;
    endfunction

    function automatic int par8(longint x);
        int n = 0;
        for (int i = 0; i < 8; i++) n += int'((x >> i) & 1);
        return (n % 2 == 0) ? 1 : 0;
    endfunction

    task automatic model(input int o_, input int w_, input longint av, input longint bv,
                         input int f_, output longint r, output int f, output int wen);
        int bits = (w_ == 0) ? 8 : (w_ == 1) ? 16 : 32;
        longint mask = (longint'(1) << bits) - 1;
        longint am = av & mask, bm = bv & mask, t, lo, hi, s;
        int ci = f_ & 1, ai = (f_ >> 2) & 1;
        int ov = 0, sf = 0, zf = 0, af = 0, pf = 0, cf = 0;
        int al, old;
        bit add_like, sub_like;
        wen = (o_ == 7 || o_ > 11) ? 0 : 1;
        lo = -(longint'(1) << (bits - 1));
        hi = (longint'(1) << (bits - 1)) - 1;
        add_like = (o_ == 0 || o_ == 2 || o_ == 8);
        sub_like = (o_ == 3 || o_ == 5 || o_ == 7 || o_ == 9);
        if (o_ >= 8 && o_ <= 9) bm = 1;
        if (add_like) begin
            int cin = (o_ == 2) ? ci : 0;
            t  = am + bm + cin;
            r  = t & mask;
            cf = int'((t >> bits) & 1);
            af = ((am & 15) + (bm & 15) + cin > 15) ? 1 : 0;
            s  = sval(am, bits) + sval(bm, bits) + cin;
            ov = (s < lo || s > hi) ? 1 : 0;
        end else if (sub_like) begin
            int bin = (o_ == 3) ? ci : 0;
            t  = am - bm - bin;
            r  = t & mask;
            cf = (t < 0) ? 1 : 0;
            af = ((am & 15) - (bm & 15) - bin < 0) ? 1 : 0;
            s  = sval(am, bits) - sval(bm, bits) - bin;
            ov = (s < lo || s > hi) ? 1 : 0;
        end else if (o_ == 1 || o_ == 4 || o_ == 6) begin
            r = (o_ == 1) ? (am | bm) : (o_ == 4) ? (am & bm) : (am ^ bm);
        end
        if (o_ == 8 || o_ == 9) cf = ci;
        if (o_ <= 9) begin
            sf = int'((r >> (bits - 1)) & 1);
            zf = (r == 0) ? 1 : 0;
            pf = par8(r);
            f  = (ov << 5) | (sf << 4) | (zf << 3) | (af << 2) | (pf << 1) | cf;
        end else if (o_ <= 11) begin
            al = int'(av & 255); old = al;
            if ((al & 15) > 9 || ai == 1) begin
                al = (o_ == 10) ? al + 6 : al - 6;
                cf = (ci == 1 || al > 255 || al < 0) ? 1 : 0;
                al = al & 255; af = 1;
            end
            if (old > 'h99 || ci == 1) begin
                al = (o_ == 10) ? ((al + 'h60) & 255) : ((al - 'h60) & 255);
                cf = 1;
            end else cf = 0;
            r  = (av & 64'hFFFF_FF00) | longint'(al);
            sf = (al >> 7) & 1;
            zf = (al == 0) ? 1 : 0;
            pf = par8(al);
            f  = (sf << 4) | (zf << 3) | (af << 2) | (pf << 1) | cf;
        end else begin
            r = 0;
            f = f_;
        end
    endtask

    function automatic string tag_of(int o_);
        case (o_)
            0, 5:     return "R1";
            2, 3:     return "R2";
            1, 4, 6:  return "R5";
            7:        return "R6";
            8, 9:     return "R7";
            10:       return "R8";
            11:       return "R9";
            default:  return "R11";
        endcase
    endfunction

    task automatic run(input int o_, input int w_, input longint av, input longint bv,
                       input int f_, input string tag);
        longint er; int ef, ew;
        @(posedge clk);
        op = 4'(o_); wd = 2'(w_); a = DW'(av); b = DW'(bv); fi = 6'(f_);
        model(o_, w_, av, bv, f_, er, ef, ew);
        @(negedge clk);
        total++;
        if (res !== DW'(er) || fo !== 6'(ef) || we !== 1'(ew)) begin
            bad++;
            $display("FAIL %s op=%0d w=%0d a=%h b=%h fi=%b: got res=%h fl=%b we=%b exp res=%h fl=%b we=%0d",
                     tag, o_, w_, av, bv, f_, res, fo, we, DW'(er), 6'(ef), ew);
        end
    endtask

    initial begin
        op = '0; wd = '0; a = '0; b = '0; fi = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset-state style check: all-zero inputs give ADD 0+0 with Z and P (R4)
        run(0, 0, 0, 0, 0, "R4");
        run(0, 0, 'h7F, 1, 0, "R3");                 // 8-bit signed overflow, aux
        run(0, 0, 'hFF, 1, 0, "R3");                 // 8-bit carry, zero
        run(5, 1, 'h8000, 1, 0, "R3");               // 16-bit signed overflow on sub
        run(5, 2, 0, 1, 0, "R3");                    // 32-bit borrow
        run(2, 2, 'hFFFF_FFFF, 0, 1, "R2");          // ADC wraps on carry-in
        run(3, 0, 'h10, 'h0F, 1, "R2");              // SBB borrow-in
        run(0, 0, 'h1FF, 'h201, 0, "R1");            // upper bits discarded at 8
        run(4, 1, 'hFFFF_8001, 'h1_8003, 'h3F, "R5");
        run(6, 0, 'hAA, 'hAA, 'h3F, "R5");
        run(7, 2, 5, 9, 0, "R6");
        run(8, 0, 'hFF, 'h1234, 1, "R7");            // INC keeps C=1, b ignored
        run(9, 1, 0, 'h55, 0, "R7");                 // DEC wraps, keeps C=0
        run(10, 0, 'h1234_569A, 0, 0, "R8");
        run(10, 2, 'h0000_0015, 0, 'b000100, "R8");  // incoming A
        run(10, 1, 'h0000_0022, 0, 'b000001, "R10"); // incoming C, width ignored
        run(11, 0, 'h0000_00FA, 0, 0, "R9");
        run(11, 0, 'hFFFF_0000, 0, 'b000101, "R9");
        run(12, 0, 'h1234, 'h5678, 'h2A, "R11");
        run(15, 2, 'hFFFF, 1, 'h15, "R11");
        run(0, 3, 'hFFFF_FFFF, 1, 0, "R12");         // width code 3 is 32-bit
        run(5, 3, 'h8000_0000, 1, 0, "R12");
        for (int i = 0; i < 3000; i++) begin
            int o_ = $urandom_range(0, 15);
            int w_ = $urandom_range(0, 3);
            longint av = longint'($urandom);
            longint bv = longint'($urandom);
            if (i % 4 == 0) av = av & 'hFF;
            if (i % 8 == 1) bv = longint'($urandom_range(0, 2)) + ((i % 3 == 0) ? 'h7F : 'h7FFF);
            run(o_, w_, av, bv, $urandom_range(0, 63), tag_of(o_));
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule